// File: doc/BRIEF.md
# Cartridge Real-Time Clock With Latch

This block is the timekeeping and bank-control logic of a game cartridge. It keeps a live clock made of seconds, minutes, hours and a 9-bit day count. The day-high register also holds a halt flag and a sticky day-overflow flag. A one-second tick input drives the clock. Software never reads the live counters directly. It reads a snapshot, which is copied from the live counters when a latch register goes from 0 to 1.

The host CPU reaches the block through plain byte writes into four control regions of the cartridge address space, plus the external-RAM window. The block also keeps the 7-bit switchable ROM bank number. It applies the rule that the external-RAM window, and so the clock registers, can be used only after an enable code has been written. When the bank-select value does not pick a clock register, the window falls through to external RAM. In that case the block only exports the bank number and an access flag.

Top module: `cart_rtc_ctrl`

## Requirements
- R1: A write to 0x0000-0x1FFF enables the external-RAM window when the low nibble of the data is 0xA, and disables it for any other value.
- R2: While the window is disabled, rdData is 0xFF and ramAccess is 0. Writes to 0xA000-0xBFFF do not change any clock register.
- R3: A write to 0x4000-0x5FFF stores the low 4 data bits as the bank select. Values 8, 9, 10, 11 and 12 pick seconds, minutes, hours, day-low and day-high. Any other value, while enabled, drives ramAccess to 1, shows the value on ramBank, and leaves rdData at 0xFF.
- R4: A write to 0x2000-0x3FFF sets romBank to the low 7 data bits, with 0 replaced by 1, then reduced modulo ROM_BANKS.
- R5: A write to 0x6000-0x7FFF copies the live counters into the snapshot only when the previous latch write was 0 and this one is 1. rdData always shows the snapshot field.
- R6: A write to 0xA000-0xBFFF, with the window enabled and a clock register selected, updates the live field and not the snapshot. Seconds and minutes keep 6 bits, hours 5 bits and day-low 8 bits. In day-high, bit 0 is day bit 8, bit 6 is halt and bit 7 is overflow. All other read bits are 0.
- R7: Each tick advances the seconds. A field at or above its limit wraps to 0 and carries: seconds at 59, minutes at 59, hours at 23.
- R8: A carry out of day 511 gives day 0 and sets the overflow flag. The flag stays set until a write to day-high clears it.
- R9: While halt is set, ticks change no counter.
- R10: When a tick and a clock write land in the same cycle, the tick is applied first and the written field takes the written value.
- R11: After reset, the window is disabled, romBank is 1, the bank select is 0, all live and snapshot fields are 0, and the previous latch value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe, one cycle per byte |
| busAddr | input | 16 | Write address |
| busWrData | input | 8 | Write data |
| secTick | input | 1 | One-second tick pulse |
| rdData | output | 8 | Byte read from the external-RAM window when a clock register is selected |
| ramAccess | output | 1 | Window enabled and served by external RAM |
| ramBank | output | 4 | Current bank select value |
| romBank | output | 7 | Switchable ROM bank number |

## Verification
The bench builds the block with ROM_BANKS set to 6, which is not a power of two. This makes the modulo reduction visible on romBank: writes of 6 and 7 give 0 and 1, and a write of 0x85 gives 5. With the default of 128 the reduction never shows. The day counter is 9 bits, so the bench loads it to 511 with direct writes and does not tick through days. A single tick then shows the full cascade from seconds to overflow.

// File: rtl/cart_rtc_pkg.sv
package cart_rtc_pkg;

  localparam int FLD_SEC = 0;
  localparam int FLD_MIN = 1;
  localparam int FLD_HR  = 2;
  localparam int FLD_DLO = 3;
  localparam int FLD_DHI = 4;

  typedef struct packed {
    logic       carry;
    logic       halt;
    logic [8:0] day;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } rtcTime_t;

  typedef struct packed {
    logic       rtcWr;
    logic [2:0] rtcField;
    logic [7:0] wrVal;
    logic       latchFire;
  } rtcStrobes_t;

endpackage

// File: rtl/cart_rtc_ctl.sv
module cart_rtc_ctl
  import cart_rtc_pkg::*;
#(
  parameter int ROM_BANKS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [15:0] busAddr,
  input  logic [7:0]  busWrData,
  output rtcStrobes_t strb,
  output logic        ramEn,
  output logic [6:0]  romBank,
  output logic [3:0]  bankSel,
  output logic        rtcSel
);

  logic [2:0] region;
  logic [7:0] latchPrev;
  logic [6:0] romNz;
  int         romMod;

  assign region = busAddr[15:13];
  assign rtcSel = (bankSel >= 4'd8) && (bankSel <= 4'd12);
  assign romNz  = (busWrData[6:0] == 7'd0) ? 7'd1 : busWrData[6:0];
  assign romMod = int'(romNz) % ROM_BANKS;

  always_comb begin
    strb.rtcWr     = busWr && (region == 3'd5) && ramEn && rtcSel;
    strb.rtcField  = 3'(bankSel - 4'd8);
    strb.wrVal     = busWrData;
    strb.latchFire = busWr && (region == 3'd3) && (latchPrev == 8'd0) && (busWrData == 8'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramEn     <= 1'b0;
      romBank   <= 7'd1;
      bankSel   <= 4'd0;
      latchPrev <= 8'd0;
    end else if (busWr) begin
      case (region)
        3'd0: ramEn     <= (busWrData[3:0] == 4'hA);
        3'd1: romBank   <= 7'(romMod);
        3'd2: bankSel   <= busWrData[3:0];
        3'd3: latchPrev <= busWrData;
        default: ;
      endcase
    end
  end

  // R1
  ram_en_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramEn) |-> ($past(busWr) && $past(busAddr[15:13]) == 3'd0 && $past(busWrData[3:0]) == 4'hA));

  // R4
  rom_bank_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && region == 3'd1 && busWrData[6:0] != 7'd0 && int'(busWrData[6:0]) < ROM_BANKS)
      |=> romBank == $past(busWrData[6:0]));

endmodule

// File: rtl/cart_rtc_time.sv
module cart_rtc_time
  import cart_rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  rtcStrobes_t strb,
  input  logic [2:0]  rdField,
  output logic [7:0]  snapByte
);

  rtcTime_t live, snap, tickd, nxt;

  always_comb begin
    tickd = live;
    if (secTick && !live.halt) begin
      if (live.sec >= 6'd59) begin
        tickd.sec = 6'd0;
        if (live.min >= 6'd59) begin
          tickd.min = 6'd0;
          if (live.hr >= 5'd23) begin
            tickd.hr = 5'd0;
            tickd.day = live.day + 9'd1;
            if (live.day == 9'd511) tickd.carry = 1'b1;
          end else begin
            tickd.hr = live.hr + 5'd1;
          end
        end else begin
          tickd.min = live.min + 6'd1;
        end
      end else begin
        tickd.sec = live.sec + 6'd1;
      end
    end
  end

  always_comb begin
    nxt = tickd;
    if (strb.rtcWr) begin
      case (int'(strb.rtcField))
        FLD_SEC: nxt.sec = strb.wrVal[5:0];
        FLD_MIN: nxt.min = strb.wrVal[5:0];
        FLD_HR:  nxt.hr  = strb.wrVal[4:0];
        FLD_DLO: nxt.day[7:0] = strb.wrVal;
        FLD_DHI: begin
          nxt.day[8] = strb.wrVal[0];
          nxt.halt   = strb.wrVal[6];
          nxt.carry  = strb.wrVal[7];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      live <= '0;
      snap <= '0;
    end else begin
      live <= nxt;
      if (strb.latchFire) snap <= live;
    end
  end

  always_comb begin
    case (int'(rdField))
      FLD_SEC: snapByte = {2'b00, snap.sec};
      FLD_MIN: snapByte = {2'b00, snap.min};
      FLD_HR:  snapByte = {3'b000, snap.hr};
      FLD_DLO: snapByte = snap.day[7:0];
      FLD_DHI: snapByte = {snap.carry, snap.halt, 5'b00000, snap.day[8]};
      default: snapByte = 8'hFF;
    endcase
  end

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchFire |=> $stable(snap));

  // R7
  sec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (live.sec < 6'd60 && !strb.rtcWr) |=> live.sec < 6'd60);

  // R8
  carry_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (live.carry && !(strb.rtcWr && int'(strb.rtcField) == FLD_DHI)) |=> live.carry);

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (live.halt && !strb.rtcWr) |=> $stable(live));

endmodule

// File: rtl/cart_rtc_ctrl.sv
module cart_rtc_ctrl
  import cart_rtc_pkg::*;
#(
  parameter int ROM_BANKS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [15:0] busAddr,
  input  logic [7:0]  busWrData,
  input  logic        secTick,
  output logic [7:0]  rdData,
  output logic        ramAccess,
  output logic [3:0]  ramBank,
  output logic [6:0]  romBank
);

  rtcStrobes_t strb;
  logic        ramEn;
  logic        rtcSel;
  logic [3:0]  bankSel;
  logic [7:0]  snapByte;

  cart_rtc_ctl #(.ROM_BANKS(ROM_BANKS)) u_ctl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .strb(strb), .ramEn(ramEn),
    .romBank(romBank), .bankSel(bankSel), .rtcSel(rtcSel)
  );

  cart_rtc_time u_time (
    .clk(clk), .rstN(rstN), .secTick(secTick), .strb(strb),
    .rdField(3'(bankSel - 4'd8)), .snapByte(snapByte)
  );

  assign rdData    = (ramEn && rtcSel) ? snapByte : 8'hFF;
  assign ramAccess = ramEn && !rtcSel;
  assign ramBank   = bankSel;

endmodule

// File: tb/cart_rtc_ctrl_bench.sv
module cart_rtc_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        secTick = 1'b0;
  logic [7:0]  rdData;
  logic        ramAccess;
  logic [3:0]  ramBank;
  logic [6:0]  romBank;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  cart_rtc_ctrl #(.ROM_BANKS(6)) u_cart_rtc_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .secTick(secTick), .rdData(rdData),
    .ramAccess(ramAccess), .ramBank(ramBank), .romBank(romBank)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d; secTick = tk;
    @(negedge clk);
    busWr = 1'b0; secTick = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic latch();
    wr(16'h6000, 8'h00);
    wr(16'h6000, 8'h01);
  endtask

  task automatic readReg(input string req, input int sel, input int exp);
    wr(16'h4000, 8'(sel));
    check(req, rdData, exp);
  endtask

  task automatic setReg(input int sel, input logic [7:0] v);
    wr(16'h4000, 8'(sel));
    wr(16'hA000, v);
  endtask

  task automatic testReset();
    check("R11 romBank", romBank, 1);
    check("R11 ramBank", ramBank, 0);
    check("R11 ramAccess", ramAccess, 0);
    check("R2 disabled read", rdData, 8'hFF);
    wr(16'h0000, 8'h0A);
    readReg("R11 snap sec", 8, 0);
    readReg("R11 snap dayhi", 12, 0);
  endtask

  task automatic testRom();
    wr(16'h2000, 8'h00); check("R4 zero->1", romBank, 1);
    wr(16'h2000, 8'h05); check("R4 load 5", romBank, 5);
    wr(16'h2000, 8'h06); check("R4 mod 6", romBank, 0);
    wr(16'h2000, 8'h07); check("R4 mod 7", romBank, 1);
    wr(16'h2000, 8'h85); check("R4 mask 7 bits", romBank, 5);
  endtask

  task automatic testEnable();
    wr(16'h1000, 8'h00);
    wr(16'h4000, 8'h08);
    check("R1 disabled", rdData, 8'hFF);
    check("R2 no access", ramAccess, 0);
    wr(16'hA000, 8'h2A);
    wr(16'h0000, 8'h1A);
    latch();
    check("R1 enable by nibble", ramAccess, 0);
    check("R2 write ignored", rdData, 0);
    wr(16'h4000, 8'h03);
    check("R3 ram access", ramAccess, 1);
    check("R3 ram bank", ramBank, 3);
    check("R3 ram rdData", rdData, 8'hFF);
    wr(16'h4000, 8'h0D);
    check("R3 bank 13 falls through", ramAccess, 1);
  endtask

  task automatic testWriteAndLatch();
    setReg(8, 8'hFB);
    readReg("R6 snapshot untouched", 8, 0);
    latch();
    check("R6 sec 6 bits", rdData, 8'h3B);
    setReg(9, 8'h25);
    setReg(10, 8'hFF);
    latch();
    readReg("R6 min", 9, 8'h25);
    readReg("R6 hr 5 bits", 10, 8'h1F);
    setReg(8, 8'h10);
    wr(16'h6000, 8'h01);
    readReg("R5 1->1 no capture", 8, 8'h3B);
    wr(16'h6000, 8'h02);
    wr(16'h6000, 8'h01);
    readReg("R5 2->1 no capture", 8, 8'h3B);
    latch();
    readReg("R5 0->1 capture", 8, 8'h10);
  endtask

  task automatic testRollover();
    setReg(8, 8'd59);
    setReg(9, 8'd59);
    setReg(10, 8'd23);
    setReg(11, 8'hFF);
    setReg(12, 8'h01);
    tick();
    latch();
    readReg("R7 sec wrap", 8, 0);
    readReg("R7 min wrap", 9, 0);
    readReg("R7 hr wrap", 10, 0);
    readReg("R8 day low 0", 11, 0);
    readReg("R8 overflow set", 12, 8'h80);
    tick(); tick();
    latch();
    readReg("R8 still set", 12, 8'h80);
    readReg("R7 sec 2", 8, 2);
    setReg(12, 8'h00);
    latch();
    readReg("R8 cleared", 12, 0);
    setReg(8, 8'd62);
    setReg(9, 8'd7);
    tick();
    latch();
    readReg("R7 over-limit wrap sec", 8, 0);
    readReg("R7 over-limit carry", 9, 8);
  endtask

  task automatic testHalt();
    setReg(8, 8'd5);
    setReg(12, 8'h40);
    tick(); tick(); tick();
    latch();
    readReg("R9 halted sec", 8, 5);
    readReg("R9 halt bit", 12, 8'h40);
    setReg(12, 8'h00);
    tick();
    latch();
    readReg("R9 resumed", 8, 6);
  endtask

  task automatic testTickWrite();
    setReg(8, 8'd59);
    setReg(9, 8'd10);
    wr(16'hA000, 8'd30, 1'b1);
    latch();
    readReg("R10 tick applied", 8, 0);
    readReg("R10 write wins", 9, 30);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        testReset();
        testRom();
        testEnable();
        wr(16'h0000, 8'h0A);
        testWriteAndLatch();
        testRollover();
        testHalt();
        testTickWrite();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule